// File: doc/BRIEF.md
# Snooping Three-State Line Coherence Controller

This block keeps one private write-back cache coherent with its peers on a shared snooping bus. For every line of a small direct-mapped array it holds a tag, a one-word data value and one of three states: invalid, shared (clean, possibly copied elsewhere), or exclusive (dirty, the only valid copy). Processor reads and writes are served from the array when possible. Otherwise the block issues exactly one bus transaction at a time: a read miss, a write miss, or a write-back of a dirty victim.

The block also watches every transaction that other caches place on the bus. When a foreign read miss hits a local exclusive line, the block supplies the data and keeps a shared copy. When a foreign write miss hits a local copy, the block drops that copy, and supplies the data first if the copy was exclusive. Snoops are handled in the cycle they appear. They win over a new processor request. A write hit on a shared line is sent out as a plain write miss; there is no separate upgrade command.

Top module: `snoop_msi_ctrl`

## Requirements
- R1: After reset every line is invalid, `cpuReady`, `busReqValid` and `snpFlush` are low, and the first access to any address goes to the bus.
- R2: A processor read whose tag matches a shared or exclusive line completes in the cycle it is presented (`cpuReady` high), returns the line data, and issues no bus transaction.
- R3: A processor read to an invalid line, or one that conflicts with a shared line, issues one read miss (`busReqCmd` = 1) for the requested address. `cpuReady` rises in the cycle `busDone` is high, `cpuRdata` equals `busFillData`, and the line becomes shared.
- R4: A processor access that conflicts with an exclusive line first issues a write-back (`busReqCmd` = 3) carrying the victim address {victim tag, index} and its data. Only after that write-back is accepted does the block issue the miss for the new address.
- R5: A processor write that matches an exclusive line completes in the cycle it is presented, updates the data, and issues no bus transaction.
- R6: A processor write that matches a shared line issues one write miss (`busReqCmd` = 2) for its address. Afterwards the line is exclusive and holds the write data.
- R7: A processor write to an invalid line, or one that conflicts with a shared line, issues one write miss. Afterwards the line is exclusive and holds the write data.
- R8: A foreign snooped read miss (`snpCmd` = 1) that matches a shared line drives nothing (`snpFlush` low) and leaves the line shared.
- R9: A foreign snooped read miss that matches an exclusive line raises `snpFlush` in the same cycle, with `snpData` equal to the line data. The line becomes shared.
- R10: A foreign snooped write miss (`snpCmd` = 2) that matches a line invalidates it. If the line was exclusive, `snpFlush` and `snpData` present its data in that cycle.
- R11: In a cycle with a foreign snooped read or write miss, a new processor request is not accepted (`cpuReady` stays low).
- R12: A snooped transaction marked with `snpFromSelf` has no effect on any line and never raises `snpFlush`.
- R13: The bus request has a single command field coded 1 read miss, 2 write miss, 3 write-back. Only one request is outstanding at a time, and it is never raised while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuValid | input | 1 | Processor request present; held with its fields until `cpuReady` |
| cpuWrite | input | 1 | 1 for a write, 0 for a read |
| cpuAddr | input | ADDR_W | Word address, {tag, index} |
| cpuWdata | input | DATA_W | Write data |
| cpuReady | output | 1 | Request completes this cycle |
| cpuRdata | output | DATA_W | Read data, valid with `cpuReady` |
| busReqValid | output | 1 | Bus transaction requested |
| busReqCmd | output | 2 | 1 read miss, 2 write miss, 3 write-back |
| busReqAddr | output | ADDR_W | Transaction address |
| busReqData | output | DATA_W | Write-back data |
| busDone | input | 1 | Current transaction accepted or filled this cycle |
| busFillData | input | DATA_W | Fill data, valid with `busDone` on a miss |
| snpValid | input | 1 | A transaction is visible on the bus |
| snpCmd | input | 2 | Command of the snooped transaction |
| snpAddr | input | ADDR_W | Address of the snooped transaction |
| snpFromSelf | input | 1 | Snooped transaction was issued by this block |
| snpFlush | output | 1 | This cache drives the block on the bus this cycle |
| snpData | output | DATA_W | Block data driven with `snpFlush` |

## Verification
A wrong line state shows up at the ports at the next access to that line. A stale exclusive state makes a later conflict produce a write-back that should not be there. A stale shared state makes a write hit put out a write miss, or leaves a snoop without a flush. A state wrongly left invalid turns the next read into a miss. The bench keeps its own model of the tag, state and data of every line. It predicts each bus command, address and data word, each flush and each read value, so a divergence is reported at the first operation that touches the affected index.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_EXC = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    BC_NONE   = 2'd0,
    BC_RDMISS = 2'd1,
    BC_WRMISS = 2'd2,
    BC_WRBACK = 2'd3
  } bus_cmd_e;

  // strobes from control to line storage
  typedef struct packed {
    logic cpuWr;     // write hit on exclusive line
    logic fill;      // miss completed: install tag, data, state
    logic fillExc;   // fill as exclusive with processor data
    logic wbInv;     // victim written back: invalidate
    logic snpUpd;    // snoop changes state of the snooped line
    logic snpToInv;  // snoop target state: 1 invalid, 0 shared
  } strobe_t;

endpackage

// File: rtl/snoop_lines.sv
module snoop_lines
  import snoop_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           ctl,
  input  logic [IDX_W-1:0]  cpuIdx,
  input  logic [TAG_W-1:0]  cpuTag,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] busFillData,
  input  logic [IDX_W-1:0]  snpIdx,
  input  logic [TAG_W-1:0]  snpTag,
  output line_st_e          cpuSt,
  output logic              cpuTagHit,
  output logic [TAG_W-1:0]  cpuLineTag,
  output logic [DATA_W-1:0] cpuLineData,
  output line_st_e          snpSt,
  output logic              snpTagHit,
  output logic [DATA_W-1:0] snpLineData
);
  localparam int LINES = 1 << IDX_W;

  line_st_e          stArr   [LINES];
  logic [TAG_W-1:0]  tagArr  [LINES];
  logic [DATA_W-1:0] dataArr [LINES];

  assign cpuSt       = stArr[cpuIdx];
  assign cpuLineTag  = tagArr[cpuIdx];
  assign cpuLineData = dataArr[cpuIdx];
  assign cpuTagHit   = (tagArr[cpuIdx] == cpuTag);
  assign snpSt       = stArr[snpIdx];
  assign snpTagHit   = (tagArr[snpIdx] == snpTag);
  assign snpLineData = dataArr[snpIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) begin
        stArr[i]   <= LN_INV;
        tagArr[i]  <= '0;
        dataArr[i] <= '0;
      end
    end else begin
      // snoop first; processor-side updates override on the same index
      if (ctl.snpUpd) stArr[snpIdx] <= ctl.snpToInv ? LN_INV : LN_SHR;
      if (ctl.wbInv)  stArr[cpuIdx] <= LN_INV;
      if (ctl.cpuWr)  dataArr[cpuIdx] <= cpuWdata;
      if (ctl.fill) begin
        tagArr[cpuIdx]  <= cpuTag;
        stArr[cpuIdx]   <= ctl.fillExc ? LN_EXC : LN_SHR;
        dataArr[cpuIdx] <= ctl.fillExc ? cpuWdata : busFillData;
      end
    end
  end

  // R3/R7: a completed fill leaves a valid line carrying the requested tag
  a_r7_fill_installs: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fill |=> (stArr[$past(cpuIdx)] != LN_INV) && (tagArr[$past(cpuIdx)] == $past(cpuTag)));

  // R9/R10: a snoop update never leaves the line exclusive
  a_r9_snoop_drops_excl: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.snpUpd && !(ctl.fill && cpuIdx == snpIdx)) |=> stArr[$past(snpIdx)] != LN_EXC);

endmodule

// File: rtl/snoop_fsm.sv
module snoop_fsm
  import snoop_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuValid,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuReady,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              busReqValid,
  output logic [1:0]        busReqCmd,
  output logic [ADDR_W-1:0] busReqAddr,
  output logic [DATA_W-1:0] busReqData,
  input  logic              busDone,
  input  logic [DATA_W-1:0] busFillData,
  input  logic              snpValid,
  input  logic [1:0]        snpCmd,
  input  logic              snpFromSelf,
  output logic              snpFlush,
  input  line_st_e          cpuSt,
  input  logic              cpuTagHit,
  input  logic [ADDR_W-IDX_W-1:0] cpuLineTag,
  input  logic [DATA_W-1:0] cpuLineData,
  input  line_st_e          snpSt,
  input  logic              snpTagHit,
  output strobe_t           ctl
);
  typedef enum logic [1:0] {FS_IDLE, FS_WB, FS_MISS} fsm_e;
  fsm_e cur, nxt;

  logic snpActive, snpMatch, lineHit, go;

  assign snpActive = snpValid && !snpFromSelf &&
                     (snpCmd == BC_RDMISS || snpCmd == BC_WRMISS);
  assign snpMatch  = snpActive && snpTagHit && (snpSt != LN_INV);
  assign snpFlush  = snpMatch && (snpSt == LN_EXC);
  assign lineHit   = cpuTagHit && (cpuSt != LN_INV);
  assign go        = cpuValid && !snpActive;
  assign cpuRdata  = (cur == FS_MISS) ? busFillData : cpuLineData;

  always_comb begin
    nxt          = cur;
    ctl          = '0;
    ctl.snpUpd   = snpMatch && (snpCmd == BC_WRMISS || snpSt == LN_EXC);
    ctl.snpToInv = (snpCmd == BC_WRMISS);
    cpuReady     = 1'b0;
    busReqValid  = 1'b0;
    busReqCmd    = BC_NONE;
    busReqAddr   = cpuAddr;
    busReqData   = cpuWdata;
    case (cur)
      FS_IDLE: begin
        if (go) begin
          if (lineHit && !cpuWrite) begin
            cpuReady = 1'b1;
          end else if (lineHit && cpuSt == LN_EXC) begin
            cpuReady  = 1'b1;
            ctl.cpuWr = 1'b1;
          end else begin
            nxt = (!lineHit && cpuSt == LN_EXC) ? FS_WB : FS_MISS;
          end
        end
      end
      FS_WB: begin
        // a snoop may already have taken the victim; then skip the write-back
        if (cpuSt == LN_EXC) begin
          busReqValid = 1'b1;
          busReqCmd   = BC_WRBACK;
          busReqAddr  = {cpuLineTag, cpuAddr[IDX_W-1:0]};
          busReqData  = cpuLineData;
          if (busDone) begin
            ctl.wbInv = 1'b1;
            nxt       = FS_MISS;
          end
        end else begin
          nxt = FS_MISS;
        end
      end
      default: begin
        busReqValid = 1'b1;
        busReqCmd   = cpuWrite ? BC_WRMISS : BC_RDMISS;
        if (busDone) begin
          ctl.fill    = 1'b1;
          ctl.fillExc = cpuWrite;
          cpuReady    = 1'b1;
          nxt         = FS_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) cur <= FS_IDLE;
    else       cur <= nxt;
  end

  // R13: idle never drives the bus; a request always carries a real command
  a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (cur == FS_IDLE) |-> !busReqValid);
  a_r13_cmd_coded: assert property (@(posedge clk) disable iff (!rstN)
    busReqValid |-> (busReqCmd != BC_NONE));
  // R4: the processor is never released while a write-back is on the bus
  a_r4_wb_holds_cpu: assert property (@(posedge clk) disable iff (!rstN)
    (busReqValid && busReqCmd == BC_WRBACK) |-> !cpuReady);
  // R11: a foreign snoop blocks a new processor request
  a_r11_snoop_first: assert property (@(posedge clk) disable iff (!rstN)
    (snpActive && cur == FS_IDLE) |-> !cpuReady);

endmodule

// File: rtl/snoop_msi_ctrl.sv
module snoop_msi_ctrl
  import snoop_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuValid,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuReady,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              busReqValid,
  output logic [1:0]        busReqCmd,
  output logic [ADDR_W-1:0] busReqAddr,
  output logic [DATA_W-1:0] busReqData,
  input  logic              busDone,
  input  logic [DATA_W-1:0] busFillData,
  input  logic              snpValid,
  input  logic [1:0]        snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic              snpFromSelf,
  output logic              snpFlush,
  output logic [DATA_W-1:0] snpData
);
  localparam int TAG_W = ADDR_W - IDX_W;

  strobe_t           ctl;
  line_st_e          cpuSt, snpSt;
  logic              cpuTagHit, snpTagHit;
  logic [TAG_W-1:0]  cpuLineTag;
  logic [DATA_W-1:0] cpuLineData;

  snoop_lines #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .cpuIdx(cpuAddr[IDX_W-1:0]), .cpuTag(cpuAddr[ADDR_W-1:IDX_W]),
    .cpuWdata(cpuWdata), .busFillData(busFillData),
    .snpIdx(snpAddr[IDX_W-1:0]), .snpTag(snpAddr[ADDR_W-1:IDX_W]),
    .cpuSt(cpuSt), .cpuTagHit(cpuTagHit), .cpuLineTag(cpuLineTag),
    .cpuLineData(cpuLineData), .snpSt(snpSt), .snpTagHit(snpTagHit),
    .snpLineData(snpData)
  );

  snoop_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rstN(rstN),
    .cpuValid(cpuValid), .cpuWrite(cpuWrite), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuReady(cpuReady), .cpuRdata(cpuRdata),
    .busReqValid(busReqValid), .busReqCmd(busReqCmd),
    .busReqAddr(busReqAddr), .busReqData(busReqData),
    .busDone(busDone), .busFillData(busFillData),
    .snpValid(snpValid), .snpCmd(snpCmd), .snpFromSelf(snpFromSelf),
    .snpFlush(snpFlush),
    .cpuSt(cpuSt), .cpuTagHit(cpuTagHit), .cpuLineTag(cpuLineTag),
    .cpuLineData(cpuLineData), .snpSt(snpSt), .snpTagHit(snpTagHit),
    .ctl(ctl)
  );

endmodule

// File: tb/test_snoop_msi_ctrl.sv
module test_snoop_msi_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuValid = 1'b0, cpuWrite = 1'b0;
  logic [7:0] cpuAddr = '0, cpuWdata = '0;
  logic cpuReady;
  logic [7:0] cpuRdata;
  logic busReqValid;
  logic [1:0] busReqCmd;
  logic [7:0] busReqAddr, busReqData;
  logic busDone = 1'b0;
  logic [7:0] busFillData = '0;
  logic snpValid = 1'b0, snpFromSelf = 1'b0;
  logic [1:0] snpCmd = '0;
  logic [7:0] snpAddr = '0;
  logic snpFlush;
  logic [7:0] snpData;

  int total = 0, bad = 0;
  int mem [256];
  int mSt [LINES];   // 0 invalid, 1 shared, 2 exclusive
  int mTag [LINES];
  int mData [LINES];

  always #(CLK_PERIOD/2) clk = ~clk;

  snoop_msi_ctrl i_snoop_msi_ctrl (
    .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .cpuWrite(cpuWrite),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuReady(cpuReady),
    .cpuRdata(cpuRdata), .busReqValid(busReqValid), .busReqCmd(busReqCmd),
    .busReqAddr(busReqAddr), .busReqData(busReqData), .busDone(busDone),
    .busFillData(busFillData), .snpValid(snpValid), .snpCmd(snpCmd),
    .snpAddr(snpAddr), .snpFromSelf(snpFromSelf), .snpFlush(snpFlush),
    .snpData(snpData)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic cpuOp(input bit w, input int a, input int wd);
    int idx = a % LINES;
    int tg = a / LINES;
    bit hit = (mSt[idx] != 0) && (mTag[idx] == tg);
    int eC [2], eA [2], eD [2];
    int gC [4], gA [4], gD [4];
    int expN = 0, gotN = 0, expR = 0, gotR = 0;
    bit fin = 0;
    string rq;
    if (hit && (!w || mSt[idx] == 2)) begin
      rq = w ? "R5" : "R2";
      expR = mData[idx];
      if (w) mData[idx] = wd;
    end else begin
      if (!hit && mSt[idx] == 2) begin
        eC[0] = 3; eA[0] = mTag[idx] * LINES + idx; eD[0] = mData[idx];
        expN = 1; rq = "R4";
      end else rq = w ? (hit ? "R6" : "R7") : "R3";
      eC[expN] = w ? 2 : 1; eA[expN] = a; eD[expN] = 0; expN++;
      expR = mem[a];
      mTag[idx] = tg; mSt[idx] = w ? 2 : 1; mData[idx] = w ? wd : mem[a];
    end
    cpuValid = 1'b1; cpuWrite = w; cpuAddr = 8'(a); cpuWdata = 8'(wd);
    for (int cyc = 0; cyc < 8 && !fin; cyc++) begin
      @(negedge clk);
      if (busReqValid) begin
        if (gotN < 4) begin
          gC[gotN] = int'(busReqCmd); gA[gotN] = int'(busReqAddr);
          gD[gotN] = int'(busReqData);
        end
        gotN++;
        if (busReqCmd == 2'd3) mem[busReqAddr] = int'(busReqData);
        busFillData = 8'(mem[busReqAddr]);
        busDone = 1'b1;
      end
      #1;
      if (cpuReady) begin gotR = int'(cpuRdata); fin = 1; end
      @(posedge clk); #1;
      busDone = 1'b0;
    end
    cpuValid = 1'b0;
    chk(fin, rq, "request completion", int'(fin), 1);
    chk(gotN == expN, rq, "bus transaction count", gotN, expN);
    for (int k = 0; k < expN && k < gotN; k++) begin
      chk(gC[k] == eC[k], (eC[k] == 3) ? "R4" : "R13", "bus command", gC[k], eC[k]);
      chk(gA[k] == eA[k], rq, "bus address", gA[k], eA[k]);
      if (eC[k] == 3) chk(gD[k] == eD[k], "R4", "write-back data", gD[k], eD[k]);
    end
    if (!w) chk(gotR == expR, rq, "read data", gotR, expR);
  endtask

  task automatic snoop(input int cmd, input int a, input bit self);
    int idx = a % LINES;
    bit match = !self && (cmd == 1 || cmd == 2) && mSt[idx] != 0 && mTag[idx] == a / LINES;
    bit expF = match && mSt[idx] == 2;
    string rq = self ? "R12" : (cmd == 2 ? "R10" : (expF ? "R9" : "R8"));
    snpValid = 1'b1; snpCmd = 2'(cmd); snpAddr = 8'(a); snpFromSelf = self;
    if (!self) begin cpuValid = 1'b1; cpuWrite = 1'b0; cpuAddr = 8'(a); end
    @(negedge clk); #1;
    chk(snpFlush == expF, rq, "flush", int'(snpFlush), int'(expF));
    if (expF) begin
      chk(int'(snpData) == mData[idx], rq, "flush data", int'(snpData), mData[idx]);
      mem[a] = int'(snpData);
    end
    if (!self) chk(!cpuReady, "R11", "cpuReady during snoop", int'(cpuReady), 0);
    @(posedge clk); #1;
    snpValid = 1'b0; cpuValid = 1'b0;
    if (match) begin
      if (cmd == 2) mSt[idx] = 0;
      else if (mSt[idx] == 2) mSt[idx] = 1;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] lf = 16'hACE1;
    for (int i = 0; i < 256; i++) mem[i] = (i * 37 + 11) & 255;
    for (int i = 0; i < LINES; i++) begin mSt[i] = 0; mTag[i] = 0; mData[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    // R1: quiet outputs in reset and after release
    chk(!cpuReady && !busReqValid && !snpFlush, "R1", "outputs in reset",
        int'(cpuReady) + int'(busReqValid) + int'(snpFlush), 0);
    rstN = 1'b1;
    @(posedge clk); #1;
    chk(!busReqValid, "R1", "bus idle after reset", int'(busReqValid), 0);
    // R1: every index misses first, even tag 0
    for (int i = 0; i < LINES; i++) cpuOp(0, i, 0);
    // directed: exclusive line read snooped, then write hit on shared (R9, R6)
    cpuOp(1, 8'h15, 8'h5A);
    snoop(1, 8'h15, 0);
    cpuOp(1, 8'h15, 8'h66);
    snoop(2, 8'h15, 1);        // R12: own write miss ignored
    cpuOp(0, 8'h15, 0);        // R2: still exclusive hit
    cpuOp(0, 8'h25, 0);        // R4: conflict with exclusive
    snoop(1, 8'h25, 0);        // R8: shared, no flush
    cpuOp(0, 8'h25, 0);        // R2
    // near-exhaustive mixed sweep over 4 indices x 3 tags
    for (int n = 0; n < 3000; n++) begin
      int r, idx, tg, a;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      r = int'(lf);
      idx = (r >> 4) % LINES;
      tg = ((r >> 7) % 3) * 5 + 1;
      a = tg * LINES + idx;
      case (r % 6)
        0, 1: cpuOp(0, a, 0);
        2, 3: cpuOp(1, a, (r >> 3) & 255);
        4:    snoop(((r >> 9) & 1) + 1, a, 0);
        default: snoop(((r >> 9) & 1) + 1, a, 1);
      endcase
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule